// File: doc/BRIEF.md
# Multiplexed-Bus CPU Register Port

This block is the slave side of an 8-bit asynchronous microprocessor bus with a 9-bit address. It lets a host processor reach a small register file through active-low chip select, read strobe and write strobe lines. An address latch enable input controls a transparent latch on the address lines. The latch follows the address bus while the enable is high and holds it once the enable falls, so the port also works on a bus that shares address and data pins. A host on a plain bus ties the enable high and the address flows straight through.

The strobes arrive with no relation to the local clock. The port brings chip select and the write strobe into the clock domain through two-flop synchronisers. A rising write strobe becomes one single-cycle write pulse, which stores the data lines into the addressed register. A read drives the selected register's content on a registered data output. It raises an output-enable line for an external tri-state pad and drives zero when the bus is released.

The register file has two reset classes. Power-up reset restores every register. Master reset restores every register except the clock-generation group at the top of the file. That group keeps its setting, so clock programming survives a master reset. Addresses beyond the implemented registers read as zero and ignore writes.

Top module: `cpuif_regport`

## Requirements
- R1: After power-up reset, register i holds (i*29 + 64) mod 256, so register 0 reads 0x40, register 4 reads 0xB4 and register 15 reads 0xF3.
- R2: The address latch follows the address bus while `ale` is 1 and holds the last value when `ale` goes to 0. A later change on the address bus does not redirect the access.
- R3: When `wr_n` rises while `cs_n` is 0, the value on `din` is stored into the latched register. The value can be read back after the write pulse.
- R4: A write strobe cycled while `cs_n` is 1 leaves every register unchanged.
- R5: Each rise of the write strobe produces exactly one write pulse, lasting a single clock cycle.
- R6: `dout_oe` is 1 only while a synchronised read (`rd_n` and `cs_n` both 0) is in progress. Whenever `dout_oe` is 0, `dout` is 0x00.
- R7: Addresses 16 to 511 are unimplemented. Reads from them return 0x00, and writes to them change no register.
- R8: Master reset restores registers 0 to 13 to their R1 values and leaves registers 14 and 15 (clock generation) unchanged.
- R9: Power-up reset restores registers 14 and 15 as well, even after they were written.
- R10: A read strobe with `cs_n` at 1 keeps `dout_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-side clock |
| por_rst | input | 1 | Power-up reset, synchronous, active high, clears whole file |
| mst_rst | input | 1 | Master reset, synchronous, active high, spares clock registers |
| ale | input | 1 | Address latch enable, transparent while high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, commits on rising edge |
| addr | input | 9 | Host address bus |
| din | input | 8 | Host write data |
| dout | output | 8 | Registered read data, 0x00 when released |
| dout_oe | output | 1 | Output enable for the external tri-state data pad |

## Verification
The assertions assume the host holds the address, write data and chip select steady for at least four clock cycles after the write strobe rises. The synchronised write pulse samples them late. They also assume the strobe stays in each level for at least two cycles, so the synchronisers never miss an edge. The bench drives all host lines on the falling clock edge and keeps every level for five or more cycles. It changes `addr` only after `ale` has closed the latch, and it holds data and chip select for six cycles past each strobe rise, so every access stays inside these limits.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 9;
  localparam int NUM_REGS = 16;
  localparam int CLK_FIRST = 14;

  // reset value of register idx
  function automatic logic [7:0] reg_reset_value(input int idx);
    return 8'((idx * 29 + 64) % 256);
  endfunction
endpackage

// File: rtl/cpuif_addr_latch.sv
module cpuif_addr_latch #(
  parameter int ADDR_W = 9
) (
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_q
);
  // transparent while ale is high, holds once it falls
  always_latch begin
    if (ale) addr_q <= addr;
  end
endmodule

// File: rtl/cpuif_strobe_sync.sv
module cpuif_strobe_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_pulse,
  output logic rd_active
);
  logic wr_s1, wr_s2, wr_s3;
  logic cs_s1, cs_s2;
  logic rd_s1, rd_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_s1 <= 1'b1; wr_s2 <= 1'b1; wr_s3 <= 1'b1;
      cs_s1 <= 1'b1; cs_s2 <= 1'b1;
      rd_s1 <= 1'b0; rd_s2 <= 1'b0;
    end else begin
      wr_s1 <= wr_n;  wr_s2 <= wr_s1; wr_s3 <= wr_s2;
      cs_s1 <= cs_n;  cs_s2 <= cs_s1;
      rd_s1 <= ~rd_n & ~cs_n;
      rd_s2 <= rd_s1;
    end
  end

  // one cycle: strobe rose (old low, new high) with select still low
  assign wr_pulse  = ~wr_s3 & wr_s2 & ~cs_s2;
  assign rd_active = rd_s2;
endmodule

// File: rtl/cpuif_regfile.sv
module cpuif_regfile
  import cpuif_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 9,
  parameter int NREGS     = 16,
  parameter int CLK_START = 14
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             mst_rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata,
  output logic [NREGS*DW-1:0] regs_flat
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DW-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic sel;
    assign sel = wr_en && (waddr == AW'(i));
    if (i >= CLK_START) begin : g_clkgen
      // clock-generation class: only power-up reset
      always_ff @(posedge clk) begin
        if (por_rst)  regs[i] <= DW'(reg_reset_value(i));
        else if (sel) regs[i] <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (por_rst || mst_rst) regs[i] <= DW'(reg_reset_value(i));
        else if (sel)           regs[i] <= wdata;
      end
    end
    assign regs_flat[i*DW +: DW] = regs[i];
  end

  always_comb begin
    if (raddr < AW'(NREGS)) rdata = regs[raddr[IDX_W-1:0]];
    else                    rdata = '0;
  end
endmodule

// File: rtl/cpuif_regport.sv
module cpuif_regport
  import cpuif_pkg::*;
#(
  parameter int DW        = DATA_W,
  parameter int AW        = ADDR_W,
  parameter int NREGS     = NUM_REGS,
  parameter int CLK_START = CLK_FIRST
) (
  input  logic          clk,
  input  logic          por_rst,
  input  logic          mst_rst,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  logic          any_rst;
  logic [AW-1:0] addr_q;
  logic          wr_pulse;
  logic          rd_active;
  logic [DW-1:0] rdata;
  logic [NREGS*DW-1:0] regs_flat;

  assign any_rst = por_rst | mst_rst;

  cpuif_addr_latch #(.ADDR_W(AW)) u_latch (
    .ale(ale), .addr(addr), .addr_q(addr_q)
  );

  cpuif_strobe_sync u_sync (
    .clk(clk), .rst(any_rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_pulse(wr_pulse), .rd_active(rd_active)
  );

  cpuif_regfile #(.DW(DW), .AW(AW), .NREGS(NREGS), .CLK_START(CLK_START)) u_rf (
    .clk(clk), .por_rst(por_rst), .mst_rst(mst_rst),
    .wr_en(wr_pulse), .waddr(addr_q), .wdata(din),
    .raddr(addr_q), .rdata(rdata), .regs_flat(regs_flat)
  );

  always_ff @(posedge clk) begin
    if (any_rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_active;
      dout    <= rd_active ? rdata : '0;
    end
  end
endmodule

// File: rtl/cpuif_regport_chk.sv
module cpuif_regport_chk
  import cpuif_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NREGS     = 16,
  parameter int CLK_START = 14
) (
  input logic                clk,
  input logic                por_rst,
  input logic                mst_rst,
  input logic                wr_pulse,
  input logic [DW-1:0]       dout,
  input logic                dout_oe,
  input logic [NREGS*DW-1:0] regs_flat
);
  localparam int CLK_LO = CLK_START * DW;
  localparam int CLK_BITS = (NREGS - CLK_START) * DW;

  function automatic logic [NREGS*DW-1:0] reset_image();
    logic [NREGS*DW-1:0] v;
    for (int i = 0; i < NREGS; i++) v[i*DW +: DW] = DW'(reg_reset_value(i));
    return v;
  endfunction

  // R5
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (por_rst || mst_rst)
    wr_pulse |=> !wr_pulse);

  // R6
  oe_zero_data_chk: assert property (@(posedge clk) disable iff (por_rst || mst_rst)
    !dout_oe |-> dout == '0);

  // R3
  regs_hold_chk: assert property (@(posedge clk) disable iff (por_rst || mst_rst)
    !wr_pulse |=> $stable(regs_flat));

  // R1
  por_values_chk: assert property (@(posedge clk) disable iff (mst_rst)
    por_rst |=> regs_flat == reset_image());

  // R8
  clkgen_spared_chk: assert property (@(posedge clk) disable iff (por_rst)
    (mst_rst && !wr_pulse) |=> $stable(regs_flat[CLK_LO +: CLK_BITS]));
endmodule

bind cpuif_regport cpuif_regport_chk #(.DW(DW), .NREGS(NREGS), .CLK_START(CLK_START)) u_chk (
  .clk(clk), .por_rst(por_rst), .mst_rst(mst_rst), .wr_pulse(wr_pulse),
  .dout(dout), .dout_oe(dout_oe), .regs_flat(regs_flat)
);

// File: tb/sim_cpuif_regport.sv
module sim_cpuif_regport;
  logic       clk = 1'b0;
  logic       por_rst, mst_rst, ale, cs_n, rd_n, wr_n;
  logic [8:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic       dout_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  cpuif_regport u0 (
    .clk(clk), .por_rst(por_rst), .mst_rst(mst_rst), .ale(ale),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [7:0] rv(input int i);
    return 8'((i * 29 + 64) % 256);
  endfunction

  // {is_write, address, data-or-expected}
  localparam logic [17:0] VEC [9] = '{
    {1'b1, 9'd1,  8'h11},
    {1'b1, 9'd2,  8'h22},
    {1'b0, 9'd1,  8'h11},
    {1'b0, 9'd2,  8'h22},
    {1'b1, 9'd1,  8'h5A},
    {1'b0, 9'd1,  8'h5A},
    {1'b0, 9'd0,  8'h40},
    {1'b1, 9'd15, 8'h3C},
    {1'b0, 9'd15, 8'h3C}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [8:0] a);
    @(negedge clk); ale = 1'b1; addr = a;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); addr = 9'h1FF;  // bus moves on after latch closes
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [7:0] d, input logic sel);
    latch_addr(a);
    din = d; cs_n = ~sel;
    @(negedge clk); wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b1; din = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic [8:0] a, input logic sel,
                          output logic [7:0] val, output logic oe);
    latch_addr(a);
    cs_n = ~sel;
    @(negedge clk); rd_n = 1'b0;
    repeat (5) @(negedge clk);
    val = dout; oe = dout_oe;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_reset(input bit por);
    @(negedge clk);
    if (por) por_rst = 1'b1; else mst_rst = 1'b1;
    repeat (3) @(negedge clk);
    por_rst = 1'b0; mst_rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic       oe;
    por_rst = 1'b1; mst_rst = 1'b0; ale = 1'b0; cs_n = 1'b1;
    rd_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
    repeat (5) @(negedge clk);
    check("R6 oe at reset", {7'd0, dout_oe}, 8'h00);
    por_rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset image
    bus_read(9'd0, 1'b1, v, oe);  check("R1 reg0", v, 8'h40);
    bus_read(9'd4, 1'b1, v, oe);  check("R1 reg4", v, rv(4));
    check("R6 oe during read", {7'd0, oe}, 8'h01);
    bus_read(9'd15, 1'b1, v, oe); check("R1 reg15", v, 8'hF3);
    check("R6 released after read", dout, 8'h00);
    check("R6 oe released", {7'd0, dout_oe}, 8'h00);

    // R3 vector table
    for (int k = 0; k < 9; k++) begin
      if (VEC[k][17]) bus_write(VEC[k][16:8], VEC[k][7:0], 1'b1);
      else begin
        bus_read(VEC[k][16:8], 1'b1, v, oe);
        check("R3 table read", v, VEC[k][7:0]);
      end
    end

    // R8 master reset spares clock registers
    pulse_reset(1'b0);
    bus_read(9'd1, 1'b1, v, oe);  check("R8 reg1 restored", v, rv(1));
    bus_read(9'd2, 1'b1, v, oe);  check("R8 reg2 restored", v, rv(2));
    bus_read(9'd15, 1'b1, v, oe); check("R8 reg15 kept", v, 8'h3C);

    // R9 power-up reset restores clock registers
    pulse_reset(1'b1);
    bus_read(9'd15, 1'b1, v, oe); check("R9 reg15 restored", v, 8'hF3);

    // R4 write without chip select
    bus_write(9'd4, 8'h99, 1'b0);
    bus_read(9'd4, 1'b1, v, oe);  check("R4 reg4 unchanged", v, rv(4));

    // R7 unimplemented space
    bus_write(9'd16, 8'h77, 1'b1);
    bus_write(9'h100, 8'h77, 1'b1);
    bus_read(9'h100, 1'b1, v, oe); check("R7 read 0x100", v, 8'h00);
    bus_read(9'd16, 1'b1, v, oe);  check("R7 read 16", v, 8'h00);
    bus_read(9'd0, 1'b1, v, oe);   check("R7 reg0 unchanged", v, 8'h40);

    // R10 read without chip select
    bus_read(9'd0, 1'b0, v, oe);
    check("R10 oe low", {7'd0, oe}, 8'h00);
    check("R10 data low", v, 8'h00);

    // R2 latch holds after ale falls (bus then shows 5, then 0x1FF)
    @(negedge clk); ale = 1'b1; addr = 9'd3;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); addr = 9'd5;
    din = 8'hEE; cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(9'd3, 1'b1, v, oe); check("R2 latched target", v, 8'hEE);
    bus_read(9'd5, 1'b1, v, oe); check("R2 bus address untouched", v, rv(5));

    // R2 flow-through with ale held high
    @(negedge clk); ale = 1'b1; addr = 9'd6; cs_n = 1'b0;
    @(negedge clk); rd_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 flow-through", dout, rv(6));
    rd_n = 1'b1; cs_n = 1'b1; ale = 1'b0;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule